// File: doc/BRIEF.md
# Event-to-Core Interrupt Router

This block takes a wide vector of event pulses and turns it into one prioritized interrupt request for a processor core. The events are split into four banks of 32. Each bank has a combiner. A combiner keeps a sticky flag per event and a mask per event, and drives one output when any unmasked flag is set.

Twelve core interrupt lines carry levels 4 to 15. Level 4 is the most urgent and level 15 the least. Each line has a selector register. The selector picks one of the combiner outputs, picks a single event routed directly, or leaves the line idle. Each line latches its activity into a pending bit. An enable register gates which pending lines may be reported. The block then reports the lowest-numbered pending enabled level.

Software reads and writes everything through a small register port. It clears event flags by writing ones to them. It retires a reported level by writing that level number to an acknowledge register.

Top module: `evt_prio_router`

Register map (word addresses on `reg_addr_i`):
- 0x00+k: flag register of combiner k. A read returns the flags. A write clears every bit written as 1.
- 0x04+k: mask register of combiner k. A bit of 1 blocks that event from the combiner output.
- 0x08+j: selector of core line j, which is level 4+j. The selector is 8 bits wide.
- 0x14: enable register. Bit j enables level 4+j.
- 0x15: acknowledge register, write only. Bits [3:0] hold the level to retire.
- 0x16: status register, read only. Bit 4 is valid and bits [3:0] hold the level.

## Requirements
- R1: After reset, all of the following hold: every flag register reads 0, and every mask register reads 0xFFFFFFFF. The enable register reads 0 and `irq_valid_o` is 0. The selectors of levels 12, 13, 14 and 15 read 0, 1, 2 and 3, and every other selector reads 0xFF.
- R2: A one-cycle pulse on event e sets bit e%32 of the flag register of combiner e/32. The bit stays set after the pulse ends.
- R3: A flag write clears only the bits written as 1 and leaves the others alone. If an event arrives in the same cycle as the clear of its flag, the flag stays set.
- R4: `cmb_o[k]` is 1 exactly when combiner k has a set flag whose mask bit is 0.
- R5: A selector value of 0 to 3 drives the line from that combiner's output. With the reset selectors, combiner 0 drives level 12 and combiner 3 drives level 15.
- R6: A selector value of 4 to 127 drives the line directly from that event number. The event's mask bit does not affect this path. For example, event 32 routed to level 8 raises level 8 while its mask bit is still set.
- R7: A selector value of 128 or above leaves the line inactive, whatever the events do.
- R8: An active line sets that level's pending bit. The bit stays set after the line drops, until the level is acknowledged.
- R9: A pending level whose enable bit is 0 is not reported. It is still held, and it is reported once the enable bit is set.
- R10: `irq_valid_o` is 1 when any enabled level is pending. `irq_level_o` then gives the lowest-numbered such level.
- R11: Writing level L (4 to 15) to the acknowledge register clears the pending bit of L. If L's line is still active, the bit is set again. An acknowledge value below 4 has no effect.
- R12: The status register reads `irq_valid_o` in bit 4 and `irq_level_o` in bits [3:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 128 | Event pulses, one bit per event number |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 6 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from `reg_addr_i` |
| cmb_o | output | 4 | Combiner outputs |
| irq_valid_o | output | 1 | An enabled level is pending |
| irq_level_o | output | 4 | Lowest pending enabled level (4 to 15) |

## Verification
Events are driven in four patterns, and each one separates a different routing path:
- A single event in an unmasked bank exercises the combiner path only.
- An event routed directly while its mask bit is set shows that direct routing does not pass through the mask.
- Two levels pending together show that priority picks the lower number and that acknowledge moves the report to the next level.
- All 128 events pulsed at once, with most selectors idle or out of range, show that only the configured line responds.

Acknowledge is also tried while the source line is still active. This tells a pending bit that is set again apart from one that has been retired.

// File: rtl/evt_prio_pkg.sv
package evt_prio_pkg;
  localparam int N_CMB    = 4;
  localparam int CMB_W    = 32;
  localparam int N_LINE   = 12;
  localparam int LVL_BASE = 4;
  localparam int LVL_W    = 4;
  localparam int SEL_W    = 8;
  localparam int AW       = 6;
  localparam int DW       = 32;
  localparam int A_FLAG   = 0;
  localparam int A_MASK   = 4;
  localparam int A_SEL    = 8;
endpackage

// File: rtl/evt_prio_comb.sv
module evt_prio_comb #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] evt_i,
  input  logic         clr_we_i,
  input  logic         mask_we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] flag_o,
  output logic [W-1:0] mask_o,
  output logic         out_o
);
  logic [W-1:0] flag_q, mask_q, clr_w;

  assign clr_w = clr_we_i ? wdata_i : '0;

  // set wins over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else         flag_q <= (flag_q & ~clr_w) | evt_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mask_q <= '1;
    else if (mask_we_i) mask_q <= wdata_i;
  end

  assign flag_o = flag_q;
  assign mask_o = mask_q;
  assign out_o  = |(flag_q & ~mask_q);

  // R2
  flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i != '0) |=> ((flag_q & $past(evt_i)) == $past(evt_i)));
  // R3
  flag_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_we_i && ((evt_i & wdata_i) == '0)) |=> ((flag_q & $past(wdata_i)) == '0));
endmodule

// File: rtl/evt_prio_route.sv
module evt_prio_route #(
  parameter int N_EVT  = 128,
  parameter int N_CMB  = 4,
  parameter int N_LINE = 12,
  parameter int SEL_W  = 8
) (
  input  logic [N_EVT-1:0]             evt_i,
  input  logic [N_CMB-1:0]             cmb_i,
  input  logic [N_LINE-1:0][SEL_W-1:0] sel_i,
  output logic [N_LINE-1:0]            line_o
);
  localparam int CIW = $clog2(N_CMB);
  localparam int EIW = $clog2(N_EVT);

  for (genvar j = 0; j < N_LINE; j++) begin : g_line
    logic hit;
    always_comb begin
      if (int'(sel_i[j]) < N_CMB)      hit = cmb_i[sel_i[j][CIW-1:0]];
      else if (int'(sel_i[j]) < N_EVT) hit = evt_i[sel_i[j][EIW-1:0]];
      else                             hit = 1'b0;
    end
    assign line_o[j] = hit;
  end
endmodule

// File: rtl/evt_prio_arb.sv
module evt_prio_arb #(
  parameter int N_LINE   = 12,
  parameter int LVL_BASE = 4,
  parameter int LVL_W    = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_LINE-1:0] line_i,
  input  logic [N_LINE-1:0] en_i,
  input  logic              ack_we_i,
  input  logic [LVL_W-1:0]  ack_lvl_i,
  output logic              valid_o,
  output logic [LVL_W-1:0]  level_o
);
  logic [N_LINE-1:0] pend_q, ack_clr, act;

  always_comb begin
    ack_clr = '0;
    for (int j = 0; j < N_LINE; j++)
      if (ack_we_i && int'(ack_lvl_i) == LVL_BASE + j) ack_clr[j] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q & ~ack_clr) | line_i;
  end

  assign act = pend_q & en_i;

  // lowest index wins: scan from the top so the last hit sticks
  always_comb begin
    valid_o = 1'b0;
    level_o = '0;
    for (int j = N_LINE - 1; j >= 0; j--) begin
      if (act[j]) begin
        valid_o = 1'b1;
        level_o = LVL_W'(LVL_BASE + j);
      end
    end
  end

  logic [N_LINE-1:0] below_w;
  assign below_w = (N_LINE'(1) << (int'(level_o) - LVL_BASE)) - N_LINE'(1);

  // R10
  level_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (int'(level_o) >= LVL_BASE && int'(level_o) < LVL_BASE + N_LINE));
  // R10
  lowest_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ((pend_q & en_i & below_w) == '0));
  // R8
  pend_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_i != '0) |=> ((pend_q & $past(line_i)) == $past(line_i)));

  for (genvar j = 0; j < N_LINE; j++) begin : g_ack
    // R11
    ack_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ack_we_i && int'(ack_lvl_i) == LVL_BASE + j && !line_i[j]) |=> !pend_q[j]);
  end
endmodule

// File: rtl/evt_prio_router.sv
module evt_prio_router
  import evt_prio_pkg::*;
#(
  parameter int P_N_CMB  = N_CMB,
  parameter int P_CMB_W  = CMB_W,
  parameter int P_N_LINE = N_LINE
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [P_N_CMB*P_CMB_W-1:0] evt_i,
  input  logic                       reg_we_i,
  input  logic [AW-1:0]              reg_addr_i,
  input  logic [DW-1:0]              reg_wdata_i,
  output logic [DW-1:0]              reg_rdata_o,
  output logic [P_N_CMB-1:0]         cmb_o,
  output logic                       irq_valid_o,
  output logic [LVL_W-1:0]           irq_level_o
);
  localparam int N_EVT  = P_N_CMB * P_CMB_W;
  localparam int A_EN   = A_SEL + P_N_LINE;
  localparam int A_ACK  = A_EN + 1;
  localparam int A_STAT = A_EN + 2;
  localparam int FIRST_CMB_LINE = P_N_LINE - P_N_CMB;

  logic [P_N_CMB-1:0][P_CMB_W-1:0]  flag_w, mask_w;
  logic [P_N_CMB-1:0]               clr_we, mask_we;
  logic [P_N_LINE-1:0][SEL_W-1:0]   sel_q;
  logic [P_N_LINE-1:0]              en_q, line_w;
  logic                             ack_we;

  always_comb begin
    for (int k = 0; k < P_N_CMB; k++) begin
      clr_we[k]  = reg_we_i && int'(reg_addr_i) == A_FLAG + k;
      mask_we[k] = reg_we_i && int'(reg_addr_i) == A_MASK + k;
    end
  end
  assign ack_we = reg_we_i && int'(reg_addr_i) == A_ACK;

  for (genvar k = 0; k < P_N_CMB; k++) begin : g_cmb
    evt_prio_comb #(.W(P_CMB_W)) u_comb (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .evt_i     (evt_i[k*P_CMB_W +: P_CMB_W]),
      .clr_we_i  (clr_we[k]),
      .mask_we_i (mask_we[k]),
      .wdata_i   (reg_wdata_i[P_CMB_W-1:0]),
      .flag_o    (flag_w[k]),
      .mask_o    (mask_w[k]),
      .out_o     (cmb_o[k])
    );
  end

  // default wiring: the last lines take the combiners in order
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int j = 0; j < P_N_LINE; j++)
        sel_q[j] <= (j >= FIRST_CMB_LINE) ? SEL_W'(j - FIRST_CMB_LINE) : '1;
    end else if (reg_we_i) begin
      for (int j = 0; j < P_N_LINE; j++)
        if (int'(reg_addr_i) == A_SEL + j) sel_q[j] <= reg_wdata_i[SEL_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                   en_q <= '0;
    else if (reg_we_i && int'(reg_addr_i) == A_EN) en_q <= reg_wdata_i[P_N_LINE-1:0];
  end

  evt_prio_route #(
    .N_EVT (N_EVT),
    .N_CMB (P_N_CMB),
    .N_LINE(P_N_LINE),
    .SEL_W (SEL_W)
  ) u_route (
    .evt_i  (evt_i),
    .cmb_i  (cmb_o),
    .sel_i  (sel_q),
    .line_o (line_w)
  );

  evt_prio_arb #(
    .N_LINE  (P_N_LINE),
    .LVL_BASE(LVL_BASE),
    .LVL_W   (LVL_W)
  ) u_arb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .line_i    (line_w),
    .en_i      (en_q),
    .ack_we_i  (ack_we),
    .ack_lvl_i (reg_wdata_i[LVL_W-1:0]),
    .valid_o   (irq_valid_o),
    .level_o   (irq_level_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    for (int k = 0; k < P_N_CMB; k++) begin
      if (int'(reg_addr_i) == A_FLAG + k) reg_rdata_o = DW'(flag_w[k]);
      if (int'(reg_addr_i) == A_MASK + k) reg_rdata_o = DW'(mask_w[k]);
    end
    for (int j = 0; j < P_N_LINE; j++)
      if (int'(reg_addr_i) == A_SEL + j) reg_rdata_o = DW'(sel_q[j]);
    if (int'(reg_addr_i) == A_EN)   reg_rdata_o = DW'(en_q);
    if (int'(reg_addr_i) == A_STAT) reg_rdata_o = DW'({irq_valid_o, irq_level_o});
  end

  for (genvar j = 0; j < P_N_LINE; j++) begin : g_idle
    // R7
    idle_line_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (int'(sel_q[j]) >= N_EVT) |-> !line_w[j]);
  end
endmodule

// File: tb/evt_prio_router_test.sv
module evt_prio_router_test;
  localparam time TCK = 4ns;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [127:0] evt = '0;
  logic         we = 1'b0;
  logic [5:0]   addr = '0;
  logic [31:0]  wdata = '0;
  logic [31:0]  rdata;
  logic [3:0]   cmb;
  logic         valid;
  logic [3:0]   level;

  int n_chk = 0;
  int n_bad = 0;

  always #(TCK/2) clk = ~clk;

  evt_prio_router uut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .evt_i       (evt),
    .reg_we_i    (we),
    .reg_addr_i  (addr),
    .reg_wdata_i (wdata),
    .reg_rdata_o (rdata),
    .cmb_o       (cmb),
    .irq_valid_o (valid),
    .irq_level_o (level)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = 6'(a); wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    addr = 6'(a);
    #1;
    d = rdata;
  endtask

  task automatic pulse(input int e);
    @(negedge clk);
    evt[e] = 1'b1;
    @(negedge clk);
    evt = '0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(8'h00, d); check("R1 flag0", d, 0);
    rd(8'h04, d); check("R1 mask0", d, 32'hFFFF_FFFF);
    rd(8'h08, d); check("R1 sel lvl4", d, 32'hFF);
    rd(8'h10, d); check("R1 sel lvl12", d, 0);
    rd(8'h13, d); check("R1 sel lvl15", d, 3);
    rd(8'h14, d); check("R1 enable", d, 0);
    check("R1 valid", 32'(valid), 0);
  endtask

  task automatic t_flags;
    logic [31:0] d;
    pulse(5); pulse(40);
    rd(8'h00, d); check("R2 flag0 bit5", d, 32'h20);
    rd(8'h01, d); check("R2 flag1 bit8", d, 32'h100);
    check("R4 masked cmb", 32'(cmb), 0);
    wr(8'h04, ~32'h20);
    check("R4 unmasked cmb0", 32'(cmb), 1);
    wr(8'h01, 32'h0);
    rd(8'h01, d); check("R3 zero write keeps", d, 32'h100);
    wr(8'h00, 32'h20);
    rd(8'h00, d); check("R3 flag0 cleared", d, 0);
    check("R4 cmb0 drops", 32'(cmb), 0);
    @(negedge clk);
    evt[40] = 1'b1; we = 1'b1; addr = 6'h01; wdata = 32'h100;
    @(negedge clk);
    evt = '0; we = 1'b0;
    rd(8'h01, d); check("R3 set beats clear", d, 32'h100);
    wr(8'h01, 32'hFFFF_FFFF);
    wr(8'h04, 32'h0);
  endtask

  task automatic t_comb_route;
    logic [31:0] d;
    wr(8'h14, 32'hFFF);
    check("R9 held pend valid", 32'(valid), 1);
    check("R9 held pend level", 32'(level), 12);
    wr(8'h15, 12);
    tick(1);
    check("R8 ack idle", 32'(valid), 0);
    pulse(7); tick(2);
    check("R5 cmb0 valid", 32'(valid), 1);
    check("R5 cmb0 level12", 32'(level), 12);
    rd(8'h16, d); check("R12 status", d, 32'h1C);
    wr(8'h15, 12); tick(1);
    check("R11 re-pend", 32'(valid), 1);
    wr(8'h00, 32'h80);
    check("R8 pend after drop", 32'(valid), 1);
    wr(8'h15, 12); tick(1);
    check("R11 ack clears", 32'(valid), 0);
  endtask

  task automatic t_direct;
    logic [31:0] d;
    wr(8'h0C, 32);
    pulse(32); tick(1);
    check("R6 direct valid", 32'(valid), 1);
    check("R6 direct level8", 32'(level), 8);
    rd(8'h01, d); check("R2 direct flag", d, 1);
    pulse(7); tick(2);
    check("R10 lower wins", 32'(level), 8);
    wr(8'h15, 8); tick(1);
    check("R10 next level", 32'(level), 12);
    wr(8'h15, 3); tick(1);
    check("R11 ack 3 ignored", 32'({valid, level}), 32'h1C);
    wr(8'h00, 32'h80);
    wr(8'h15, 12); tick(1);
    check("R11 all retired", 32'(valid), 0);
    wr(8'h01, 32'hFFFF_FFFF);
  endtask

  task automatic t_enable;
    wr(8'h14, 32'hFEF);
    pulse(32); tick(2);
    check("R9 disabled", 32'(valid), 0);
    wr(8'h14, 32'hFFF);
    check("R9 enabled later", 32'({valid, level}), 32'h18);
    wr(8'h15, 8); tick(1);
    check("R9 acked", 32'(valid), 0);
  endtask

  task automatic t_inactive;
    wr(8'h04, 32'hFFFF_FFFF);
    wr(8'h09, 200);
    @(negedge clk);
    evt = '1;
    @(negedge clk);
    evt = '0;
    tick(2);
    check("R7 only lvl8", 32'({valid, level}), 32'h18);
    wr(8'h15, 8); tick(1);
    check("R7 idle lines", 32'(valid), 0);
    wr(8'h08, 3);
    wr(8'h07, 32'h0); tick(2);
    check("R4 cmb3 only", 32'(cmb), 32'h8);
    check("R5 cmb3 at lvl4", 32'({valid, level}), 32'h14);
  endtask

  initial begin
    #(TCK * 50000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(2);
    t_reset();
    t_flags();
    t_comb_route();
    t_direct();
    t_enable();
    t_inactive();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule